// File: doc/BRIEF.md
# Byte-Lane Asynchronous Pseudo-Static RAM Controller

This block sits on the host side of a 1M x 16 pseudo-static RAM with an asynchronous pin interface. It takes single-cycle requests (write flag, 20-bit word address, 16-bit write data, two byte-lane enables) and plays each one out on the memory pins as a read or write cycle. Every cycle is held for a number of clock periods. That number is computed at elaboration by rounding each nanosecond minimum up to whole clocks.

A read selects the device and turns the memory's output drivers on. It enables the lanes the host asked for and holds everything stable for the full read window. It then captures the bus, with disabled lanes forced to zero, and pulses `done`. A write runs in three phases. An address/select setup phase comes first. Next is the write-strobe-low phase, during which the host drives the data bus. A recovery phase closes the write cycle. Only the enabled lanes take data, so word, low-byte and high-byte writes all work. A request whose enables are both clear does not start a cycle. A new request is taken only while `busy` is low, so one whole memory cycle always passes before the next starts.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is high, and after reset with no request, every active-low memory control (select, read strobe, write strobe, both lane enables) is 1. The data-drive enable is 0, `busy` and `done` are 0 and `rdata` is 0. The power-select output `mem_awake` is 1 at all times.
- R2: A request with `busy` low and a nonzero `req_be` is accepted on that clock edge. `busy` is 1 from the next cycle until the access ends. Requests presented while `busy` is 1 are ignored.
- R3: A read holds select low, read strobe low and write strobe high for RD_CYC cycles (7 with the default 10 ns clock). `req_be[0]`=1 drives the low-lane enable `mem_lo_n` low (bus bits 7:0). `req_be[1]`=1 drives the high-lane enable `mem_hi_n` low (bits 15:8).
- R4: `done` is a one-cycle pulse in the cycle after an access's last cycle. After a read, `rdata` holds the bus value sampled in the last read cycle, and lanes whose enable bit is 0 read as zero.
- R5: A write holds select low with the write strobe high for WSET_CYC cycles (1). It then holds the write strobe low for WLOW_CYC cycles (5) and high again for WREC_CYC cycles (1), for 7 cycles in all.
- R6: During a write, `mem_dout_en` is 1 exactly while the write strobe is low, and `mem_dout` equals the request's write data. The lane enables follow `req_be` as in R3.
- R7: `rdata` changes only when a read completes; writes leave it unchanged.
- R8: A request with `req_be` = 2'b00 is ignored: no pin leaves its idle level, `busy` stays 0, no `done` follows and memory contents are unchanged.
- R9: `mem_a` equals the request's address and stays constant from the first to the last cycle of the access.
- R10: With a request held continuously, a new access is accepted in the cycle `done` is high, giving one access per RD_CYC+1 cycles.
- R11: The read strobe never falls in a cycle that follows one in which the host drove the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read data, disabled lanes zero |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_awake | output | 1 | Power-select, held high |
| mem_rd_n | output | 1 | Output-enable strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_lo_n | output | 1 | Low lane enable, active low |
| mem_hi_n | output | 1 | High lane enable, active low |
| mem_a | output | 20 | Memory address |
| mem_dout | output | 16 | Host data toward memory |
| mem_dout_en | output | 1 | Host drives data bus when 1 |
| mem_din | input | 16 | Data bus from memory |

## Verification
Pins change in the same cycle as the accepting edge. Reads hold for 7 cycles, and writes run 1 setup, 5 strobe-low and 1 recovery cycle. `done` and `rdata` update one edge after the last access cycle, and `busy` drops on that same edge. The bench's reference model advances one step per rising edge and carries an access counter, so the expected pin levels, `busy`, `done` and `rdata` are all known for every cycle. These are compared at each falling edge. A behavioural memory on the pins commits writes when the strobe rises and returns filler on disabled lanes, so lane masking and read-back are checked end to end.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int unsigned ADDR_W = 20;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD,
        PH_WSET,
        PH_WLOW,
        PH_WREC
    } phase_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
    } cmd_t;

    typedef struct packed {
        logic             sel_n;
        logic             rd_n;
        logic             wr_n;
        logic             dout_en;
        logic [LANES-1:0] lane_n;
    } pins_t;

    // Nanoseconds to whole clock periods, rounded up, never below one.
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned usub0(input int unsigned a, input int unsigned b);
        return (a > b) ? a - b : 0;
    endfunction

endpackage

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int unsigned RD_CYC   = 7,
    parameter int unsigned WSET_CYC = 1,
    parameter int unsigned WLOW_CYC = 5,
    parameter int unsigned WREC_CYC = 1,
    parameter int unsigned CNT_W    = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   is_write,
    output phase_t phase,
    output logic   fin,
    output logic   fin_rd
);

    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    function automatic logic [CNT_W-1:0] ld(input int unsigned n);
        return CNT_W'(n - 1);
    endfunction

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (!is_write) begin
                            phase <= PH_RD;
                            cnt   <= ld(RD_CYC);
                        end else if (WSET_CYC > 0) begin
                            phase <= PH_WSET;
                            cnt   <= ld(WSET_CYC);
                        end else begin
                            phase <= PH_WLOW;
                            cnt   <= ld(WLOW_CYC);
                        end
                    end
                end
                PH_RD: begin
                    if (cnt_zero) phase <= PH_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                PH_WSET: begin
                    if (cnt_zero) begin
                        phase <= PH_WLOW;
                        cnt   <= ld(WLOW_CYC);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_WLOW: begin
                    if (cnt_zero) begin
                        if (WREC_CYC > 0) begin
                            phase <= PH_WREC;
                            cnt   <= ld(WREC_CYC);
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_WREC: begin
                    if (cnt_zero) phase <= PH_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign fin_rd = cnt_zero && (phase == PH_RD);
    assign fin    = cnt_zero && ((phase == PH_RD) || (phase == PH_WREC) ||
                                 ((phase == PH_WLOW) && (WREC_CYC == 0)));

    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase != PH_IDLE));

endmodule

// File: rtl/psram_pins.sv
module psram_pins
    import psram_pkg::*;
(
    input  phase_t            phase,
    input  cmd_t              cmd,
    output pins_t             pins,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout
);

    logic active;
    assign active = (phase != PH_IDLE);

    for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
        assign pins.lane_n[l] = !(active && cmd.be[l]);
    end

    always_comb begin
        pins.sel_n   = !active;
        pins.rd_n    = !(phase == PH_RD);
        pins.wr_n    = !(phase == PH_WLOW);
        pins.dout_en = (phase == PH_WLOW);
        addr         = active ? cmd.addr : '0;
        dout         = (phase == PH_WLOW) ? cmd.wdata : '0;
    end

endmodule

// File: rtl/psram_rcap.sv
module psram_rcap
    import psram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fin,
    input  logic              fin_rd,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    for (genvar l = 0; l < int'(LANES); l++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst)
                rdata[l*LANE_W +: LANE_W] <= '0;
            else if (fin_rd)
                rdata[l*LANE_W +: LANE_W] <= be[l] ? din[l*LANE_W +: LANE_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= fin;
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned CLK_NS  = 10,
    parameter int unsigned T_RC_NS = 70,
    parameter int unsigned T_AA_NS = 70,
    parameter int unsigned T_OE_NS = 35,
    parameter int unsigned T_BA_NS = 70,
    parameter int unsigned T_WC_NS = 70,
    parameter int unsigned T_WP_NS = 50,
    parameter int unsigned T_AW_NS = 60,
    parameter int unsigned T_DW_NS = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [19:0]       req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rdata,
    output logic              mem_sel_n,
    output logic              mem_awake,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              mem_lo_n,
    output logic              mem_hi_n,
    output logic [19:0]       mem_a,
    output logic [15:0]       mem_dout,
    output logic              mem_dout_en,
    input  logic [15:0]       mem_din
);

    localparam int unsigned RD_CYC   = umax(umax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                                            umax(ns2cyc(T_OE_NS, CLK_NS), ns2cyc(T_BA_NS, CLK_NS)));
    localparam int unsigned WLOW_CYC = umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS));
    localparam int unsigned WSET_CYC = usub0(ns2cyc(T_AW_NS, CLK_NS), WLOW_CYC);
    localparam int unsigned WREC_CYC = usub0(ns2cyc(T_WC_NS, CLK_NS), WSET_CYC + WLOW_CYC);
    localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, WLOW_CYC), umax(WSET_CYC, WREC_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
    localparam int unsigned MON_W    = CNT_W + 1;

    phase_t phase;
    cmd_t   cmd;
    pins_t  pins;
    logic   start, fin, fin_rd;

    assign busy  = (phase != PH_IDLE);
    assign start = req && !busy && (req_be != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else if (start) begin
            cmd.addr  <= req_addr;
            cmd.wdata <= req_wdata;
            cmd.be    <= req_be;
        end
    end

    psram_seq #(
        .RD_CYC   (RD_CYC),
        .WSET_CYC (WSET_CYC),
        .WLOW_CYC (WLOW_CYC),
        .WREC_CYC (WREC_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_write (req_we),
        .phase    (phase),
        .fin      (fin),
        .fin_rd   (fin_rd)
    );

    psram_pins u_pins (
        .phase (phase),
        .cmd   (cmd),
        .pins  (pins),
        .addr  (mem_a),
        .dout  (mem_dout)
    );

    psram_rcap u_rcap (
        .clk    (clk),
        .rst    (rst),
        .fin    (fin),
        .fin_rd (fin_rd),
        .be     (cmd.be),
        .din    (mem_din),
        .rdata  (rdata),
        .done   (done)
    );

    assign mem_sel_n   = pins.sel_n;
    assign mem_rd_n    = pins.rd_n;
    assign mem_wr_n    = pins.wr_n;
    assign mem_dout_en = pins.dout_en;
    assign mem_lo_n    = pins.lane_n[0];
    assign mem_hi_n    = pins.lane_n[1];
    assign mem_awake   = 1'b1;

    // Strobe-width monitors for the timing checks below.
    logic [MON_W-1:0] wr_low_cnt, rd_low_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_low_cnt <= '0;
            rd_low_cnt <= '0;
        end else begin
            wr_low_cnt <= !mem_wr_n ? ((&wr_low_cnt) ? wr_low_cnt : wr_low_cnt + 1'b1) : '0;
            rd_low_cnt <= !mem_rd_n ? ((&rd_low_cnt) ? rd_low_cnt : rd_low_cnt + 1'b1) : '0;
        end
    end

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr_n) |-> (wr_low_cnt >= MON_W'(WLOW_CYC)));

    // R3
    rd_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd_n) |-> (rd_low_cnt >= MON_W'(RD_CYC)));

    // R8
    empty_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !busy && (req_be == 2'b00)) |=> mem_sel_n);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_sel_n && !fin) |=> $stable(mem_a));

    // R11
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_rd_n) |-> !$past(mem_dout_en));

    // R6
    drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> (!mem_wr_n && !mem_sel_n && mem_rd_n));

endmodule

// File: tb/tb_psram_ctrl.sv
module tb_psram_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int RD_LEN = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int W_LOW  = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int W_SET  = (60 + CLK_PERIOD - 1) / CLK_PERIOD - W_LOW;
    localparam int W_LEN  = (70 + CLK_PERIOD - 1) / CLK_PERIOD;

    logic clk = 0, rst = 1;
    logic req = 0, req_we = 0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic busy, done;
    logic [15:0] rdata;
    logic mem_sel_n, mem_awake, mem_rd_n, mem_wr_n, mem_lo_n, mem_hi_n, mem_dout_en;
    logic [19:0] mem_a;
    logic [15:0] mem_dout;
    logic [15:0] mem_din = 16'hC3C3;

    psram_ctrl dut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .busy(busy), .done(done), .rdata(rdata),
        .mem_sel_n(mem_sel_n), .mem_awake(mem_awake), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n), .mem_a(mem_a), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // ---------------- reference model ----------------
    bit          started = 0;
    bit          m_busy = 0, m_wr = 0, m_done = 0, was_busy;
    int          m_cnt = 0;
    logic [19:0] m_addr = '0;
    logic [15:0] m_wdata = '0, m_rdata = '0;
    logic [1:0]  m_be = '0;
    logic [15:0] shadow [int unsigned];

    function automatic logic [15:0] shadow_rd(input logic [19:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    endfunction

    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (rst) begin
            m_busy = 0; m_done = 0; m_rdata = '0;
        end else begin
            was_busy = m_busy;
            m_done = 0;
            if (m_busy) begin
                if (m_cnt == (m_wr ? W_LEN : RD_LEN) - 1) begin
                    logic [15:0] old;
                    m_busy = 0;
                    m_done = 1;
                    old = shadow_rd(m_addr);
                    if (m_wr) begin
                        shadow[int'(m_addr)] = {m_be[1] ? m_wdata[15:8] : old[15:8],
                                                m_be[0] ? m_wdata[7:0]  : old[7:0]};
                    end else begin
                        m_rdata = {m_be[1] ? old[15:8] : 8'h00, m_be[0] ? old[7:0] : 8'h00};
                    end
                end else begin
                    m_cnt++;
                end
            end
            if (!was_busy && req && req_be != 2'b00) begin
                m_busy = 1; m_wr = req_we; m_cnt = 0;
                m_addr = req_addr; m_wdata = req_wdata; m_be = req_be;
            end
        end
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- behavioural memory on the pins ----------------
    logic [15:0] dev [int unsigned];
    bit          wr_open = 0;
    logic [19:0] lat_a;
    logic [15:0] lat_d;
    bit          lat_lo, lat_hi;

    always @(negedge clk) begin
        logic [15:0] cur;
        if (!mem_sel_n && !mem_wr_n) begin
            wr_open = 1; lat_a = mem_a; lat_d = mem_dout;
            lat_lo = !mem_lo_n; lat_hi = !mem_hi_n;
        end else if (wr_open) begin
            wr_open = 0;
            cur = dev.exists(int'(lat_a)) ? dev[int'(lat_a)] : 16'h0000;
            dev[int'(lat_a)] = {lat_hi ? lat_d[15:8] : cur[15:8], lat_lo ? lat_d[7:0] : cur[7:0]};
        end
        cur = dev.exists(int'(mem_a)) ? dev[int'(mem_a)] : 16'h0000;
        if (!mem_sel_n && !mem_rd_n && mem_wr_n)
            mem_din = {!mem_hi_n ? cur[15:8] : 8'hA5, !mem_lo_n ? cur[7:0] : 8'h3C};
        else
            mem_din = 16'hC3C3;
    end

    // ---------------- per-cycle comparison ----------------
    bit prev_en = 0;
    always @(negedge clk) begin
        if (started) begin
            bit e_sel_n, e_rd_n, e_wr_n, e_lo_n, e_hi_n;
            string t3, t5, t6;
            e_sel_n = !m_busy;
            e_rd_n  = !(m_busy && !m_wr);
            e_wr_n  = !(m_busy && m_wr && m_cnt >= W_SET && m_cnt < W_SET + W_LOW);
            e_lo_n  = !(m_busy && m_be[0]);
            e_hi_n  = !(m_busy && m_be[1]);
            t3 = rst ? "R1" : "R3";
            t5 = rst ? "R1" : "R5";
            t6 = rst ? "R1" : "R6";
            chk(mem_sel_n == e_sel_n, t3, "select", mem_sel_n, e_sel_n);
            chk(mem_rd_n == e_rd_n, t3, "read strobe", mem_rd_n, e_rd_n);
            chk(mem_wr_n == e_wr_n, t5, "write strobe", mem_wr_n, e_wr_n);
            chk(mem_lo_n == e_lo_n, (m_busy && m_wr) ? "R6" : t3, "low lane", mem_lo_n, e_lo_n);
            chk(mem_hi_n == e_hi_n, (m_busy && m_wr) ? "R6" : t3, "high lane", mem_hi_n, e_hi_n);
            chk(mem_dout_en == !e_wr_n, t6, "data drive", mem_dout_en, !e_wr_n);
            if (!e_wr_n) chk(mem_dout == m_wdata, "R6", "write data", mem_dout, m_wdata);
            if (m_busy)  chk(mem_a == m_addr, "R9", "address", mem_a, m_addr);
            chk(busy == m_busy, rst ? "R1" : "R2", "busy", busy, m_busy);
            chk(done == m_done, rst ? "R1" : "R4", "done", done, m_done);
            chk(rdata == m_rdata, rst ? "R1" : ((m_done && !m_wr) ? "R4" : "R7"), "rdata", rdata, m_rdata);
            chk(mem_awake == 1'b1, "R1", "power select", mem_awake, 1);
            if (!mem_rd_n) chk(!prev_en, "R11", "turnaround", prev_en, 0);
            prev_en = mem_dout_en;
        end
    end

    // ---------------- stimulus ----------------
    task automatic op(input bit we, input logic [19:0] a, input logic [15:0] d,
                      input logic [1:0] be, output logic [15:0] rd);
        int n;
        @(negedge clk);
        req = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req = 0;
        n = 0;
        while (!done && n < 50) begin @(negedge clk); n++; end
        rd = rdata;
    endtask

    initial begin
        logic [15:0] r;
        int n;
        repeat (3) @(negedge clk);
        chk(mem_sel_n && mem_rd_n && mem_wr_n && !busy, "R1", "idle in reset",
            {mem_sel_n, mem_rd_n, mem_wr_n, busy}, 4'b1110);
        rst = 0;
        @(negedge clk);
        chk(rdata == 16'h0 && !done, "R1", "idle after reset", rdata, 0);

        op(1, 20'h00010, 16'h1234, 2'b11, r);
        op(0, 20'h00010, 16'h0, 2'b11, r);
        chk(r == 16'h1234, "R4", "word read", r, 16'h1234);
        op(1, 20'h00010, 16'hFFAB, 2'b01, r);
        op(1, 20'h00010, 16'hCDFF, 2'b10, r);
        op(0, 20'h00010, 16'h0, 2'b11, r);
        chk(r == 16'hCDAB, "R6", "lane writes merged", r, 16'hCDAB);
        op(0, 20'h00010, 16'h0, 2'b01, r);
        chk(r == 16'h00AB, "R4", "low lane read", r, 16'h00AB);
        op(0, 20'h00010, 16'h0, 2'b10, r);
        chk(r == 16'hCD00, "R4", "high lane read", r, 16'hCD00);
        op(1, 20'hFFFFF, 16'h5A5A, 2'b11, r);
        op(0, 20'hFFFFF, 16'h0, 2'b11, r);
        chk(r == 16'h5A5A, "R9", "top address", r, 16'h5A5A);

        // R8: empty lane enables
        @(negedge clk);
        req = 1; req_we = 1; req_addr = 20'h00010; req_wdata = 16'h0000; req_be = 2'b00;
        repeat (3) begin
            @(negedge clk);
            chk(!busy && mem_sel_n && !done && mem_wr_n, "R8", "empty request",
                {busy, mem_sel_n, done}, 3'b010);
        end
        req = 0;
        op(0, 20'h00010, 16'h0, 2'b11, r);
        chk(r == 16'hCDAB, "R8", "memory untouched", r, 16'hCDAB);

        // R7: write leaves rdata alone
        op(1, 20'h00040, 16'h7777, 2'b11, r);
        chk(r == 16'hCDAB, "R7", "rdata after write", r, 16'hCDAB);

        // R2: requests while busy are ignored
        @(negedge clk);
        req = 1; req_we = 1; req_addr = 20'h00020; req_wdata = 16'h1111; req_be = 2'b11;
        @(negedge clk);
        req_we = 0; req_addr = 20'h00030;
        repeat (4) begin
            chk(busy && mem_a == 20'h00020, "R2", "held while busy", mem_a, 20'h00020);
            @(negedge clk);
        end
        req = 0;
        n = 0;
        while (!done && n < 50) begin @(negedge clk); n++; end
        op(0, 20'h00020, 16'h0, 2'b11, r);
        chk(r == 16'h1111, "R2", "first request won", r, 16'h1111);

        // R10: back-to-back reads
        @(negedge clk);
        req = 1; req_we = 0; req_addr = 20'h00010; req_be = 2'b11;
        n = 0;
        repeat (24) begin
            @(negedge clk);
            if (done) n++;
        end
        req = 0;
        chk(n == 3, "R10", "accesses in 24 cycles", n, 3);
        repeat (10) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule